// File: doc/BRIEF.md
# Register-Mapped Interrupt Collector

This block gathers eight interrupt sources into a single interrupt line for a processor. Each source owns a sticky request bit. A source input that is high at a clock edge sets its bit, and the bit stays set after the source goes low. Software can also raise requests through a trigger register and drop them through a write-one-to-clear register. An enable register masks the requests, and any request that survives the mask drives the processor line.

A global allow flag gates the processor line. When the processor acknowledges, the flag clears and the line drops, even if requests are still pending. Software sets the flag again with a write to a dedicated register, and the line comes back if requests remain. All access goes through a simple synchronous register bus with a chip select, an address, separate write and read strobes, and 8-bit data in each direction. Read data is registered.

The reset input is asynchronous and active low. It resets the block at once, and its release is synchronised to the clock through two flops before the logic leaves reset.

Top module: `irq_hub`

## Requirements
- R1: After reset, cpu_irq is 0 and bus_rdata is 0x00. The request register and the enable register both read 0x00, and the allow flag is 1.
- R2: A source input that is 1 at a clock edge sets its request bit (address 0x0, read only, bit n = source n). The bit stays 1 after the source returns to 0, until software clears it.
- R3: A write to address 0x3 ORs the written ones into the request register. From 0x00, writing 0xAA then 0x55 gives 0xAA and then 0xFF.
- R4: A write to address 0x4 clears the request bits at the positions of the ones written. From 0xFF, writing 0x71 gives 0x8E, and writing 0x85 after that gives 0x0A.
- R5: If a source sets a bit in the same cycle as a clear write targets that bit, the bit ends up 1.
- R6: The enable register at address 0x1 reads back the value last written. Address 0x2 reads the pending value, which is the request register AND the enable register, bit by bit.
- R7: cpu_irq is 1 exactly when at least one pending bit is 1 and the allow flag is 1.
- R8: When cpu_ack is 1 at a clock edge, the allow flag clears, and cpu_irq is 0 from then on while requests stay pending. cpu_ack wins over an allow-set write in the same cycle.
- R9: A write to address 0x6 with data bit 0 = 1 sets the allow flag. A write there with bit 0 = 0 has no effect.
- R10: bus_rdata changes only at the edge that samples bus_sel and bus_rd both high, and it then shows the addressed value. Addresses 0x3, 0x4, 0x5, 0x6 and 0x7 read 0x00. A strobe without bus_sel is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Chip select for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| src_req | input | 8 | Interrupt source inputs, one per bit |
| cpu_ack | input | 1 | Acknowledge from the processor |
| cpu_irq | output | 1 | Interrupt line to the processor |

## Verification
The mask logic is swept over all 256 enable values, each paired with a request pattern derived from it. Each pairing reads back the pending value and checks the interrupt line, which tells a faulty AND or OR from a correct one at every bit position. Fixed trigger and clear sequences with asymmetric bit patterns separate OR-in and one-to-clear behaviour from plain overwrite. Single-source pulses, a source colliding with a clear, and an acknowledge colliding with an allow write each isolate one priority rule. A final pass reads every reserved address and issues strobes without chip select.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned MAP_REQ   = 0;
  localparam int unsigned MAP_ENA   = 1;
  localparam int unsigned MAP_PEND  = 2;
  localparam int unsigned MAP_TRIG  = 3;
  localparam int unsigned MAP_CLR   = 4;
  localparam int unsigned MAP_ALLOW = 6;

  typedef struct packed {
    logic trig;
    logic clr;
    logic ena;
    logic allow;
  } wr_strb_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_bus_if.sv
module irq_bus_if
  import irq_hub_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] req_q,
  input  logic [DATA_W-1:0] pend,
  output logic [DATA_W-1:0] ier_q,
  output wr_strb_t          strb,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] L_REQ   = ADDR_W'(MAP_REQ);
  localparam logic [ADDR_W-1:0] L_ENA   = ADDR_W'(MAP_ENA);
  localparam logic [ADDR_W-1:0] L_PEND  = ADDR_W'(MAP_PEND);
  localparam logic [ADDR_W-1:0] L_TRIG  = ADDR_W'(MAP_TRIG);
  localparam logic [ADDR_W-1:0] L_CLR   = ADDR_W'(MAP_CLR);
  localparam logic [ADDR_W-1:0] L_ALLOW = ADDR_W'(MAP_ALLOW);

  logic              wr_hit;
  logic              rd_en;
  logic [DATA_W-1:0] ier_d;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    wr_hit     = bus_sel & bus_wr;
    strb.trig  = wr_hit && (bus_addr == L_TRIG);
    strb.clr   = wr_hit && (bus_addr == L_CLR);
    strb.ena   = wr_hit && (bus_addr == L_ENA);
    strb.allow = wr_hit && (bus_addr == L_ALLOW) && bus_wdata[0];
  end

  always_comb begin
    ier_d = strb.ena ? bus_wdata : ier_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier_q <= '0;
    else        ier_q <= ier_d;
  end

  always_comb begin
    case (bus_addr)
      L_REQ:   rd_mux = req_q;
      L_ENA:   rd_mux = ier_q;
      L_PEND:  rd_mux = pend;
      default: rd_mux = '0;
    endcase
    rd_en   = bus_sel & bus_rd;
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R6
  ier_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == L_ENA) |=> (ier_q == $past(bus_wdata)));

  // R10
  reserved_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && bus_addr > L_PEND) |=> (bus_rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_rd) |=> $stable(bus_rdata));
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import irq_hub_pkg::*;
#(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  wr_strb_t        strb,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] req_q
);
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_bit
    logic set_b;
    logic clr_b;
    logic bit_d;

    always_comb begin
      set_b = src_req[gi] | (strb.trig & wdata[gi]);
      clr_b = strb.clr & wdata[gi];
      if (set_b)      bit_d = 1'b1;
      else if (clr_b) bit_d = 1'b0;
      else            bit_d = req_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[gi] <= 1'b0;
      else        req_q[gi] <= bit_d;
    end

    // R2
    src_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_req[gi] |=> req_q[gi]);

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q[gi] && !(strb.clr && wdata[gi])) |=> req_q[gi]);

    // R4
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.clr && wdata[gi] && !src_req[gi]) |=> !req_q[gi]);
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_q,
  input  logic [NSRC-1:0] ier_q,
  input  logic            allow_set,
  input  logic            cpu_ack,
  output logic [NSRC-1:0] pend,
  output logic            cpu_irq
);
  logic allow_q;
  logic allow_d;
  logic group_req;

  always_comb begin
    pend      = req_q & ier_q;
    group_req = |pend;
    if (cpu_ack)        allow_d = 1'b0;
    else if (allow_set) allow_d = 1'b1;
    else                allow_d = allow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) allow_q <= 1'b1;
    else        allow_q <= allow_d;
  end

  assign cpu_irq = group_req & allow_q;

  // R8
  ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_irq);

  // R9
  allow_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_set && !cpu_ack) |=> allow_q);

  // R7
  no_pend_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == '0) |-> !cpu_irq);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned NSRC      = 8,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  input  logic [NSRC-1:0]   src_req,
  input  logic              cpu_ack,
  output logic              cpu_irq
);
  logic            rst_int_n;
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] ier_q;
  logic [NSRC-1:0] pend;
  wr_strb_t        strb;

  irq_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irq_bus_if #(.ADDR_W(ADDR_W), .DATA_W(NSRC)) u_bus (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .req_q     (req_q),
    .pend      (pend),
    .ier_q     (ier_q),
    .strb      (strb),
    .bus_rdata (bus_rdata)
  );

  irq_req_bank #(.NSRC(NSRC)) u_req (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .src_req (src_req),
    .strb    (strb),
    .wdata   (bus_wdata),
    .req_q   (req_q)
  );

  irq_gate #(.NSRC(NSRC)) u_gate (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_q     (req_q),
    .ier_q     (ier_q),
    .allow_set (strb.allow),
    .cpu_ack   (cpu_ack),
    .pend      (pend),
    .cpu_irq   (cpu_irq)
  );
endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] src_req = '0;
  logic       cpu_ack = 1'b0;
  logic       cpu_irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_irr;
  logic [7:0] m_ier;
  logic       m_allow;
  logic [7:0] rd_val;

  always #2 clk = ~clk;

  irq_hub u_irq_hub (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_req(src_req), .cpu_ack(cpu_ack),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  function automatic logic exp_irq();
    return (|(m_irr & m_ier)) & m_allow;
  endfunction

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rdata in reset", bus_rdata, 8'h00);
    chk("R1 irq in reset", {7'b0, cpu_irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    m_irr = '0; m_ier = '0; m_allow = 1'b1;
    rd(3'd0, rd_val); chk("R1 request default", rd_val, 8'h00);
    rd(3'd1, rd_val); chk("R1 enable default", rd_val, 8'h00);
    // R1 allow flag defaults to 1: enable + trigger shows irq without allow write
    wr(3'd1, 8'h01); wr(3'd3, 8'h01);
    chk("R1 allow default", {7'b0, cpu_irq}, 8'h01);
    wr(3'd4, 8'hFF); wr(3'd1, 8'h00);

    // R3 trigger ORs in
    wr(3'd3, 8'hAA); rd(3'd0, rd_val); chk("R3 trig AA", rd_val, 8'hAA);
    wr(3'd3, 8'h55); rd(3'd0, rd_val); chk("R3 trig 55", rd_val, 8'hFF);
    // R4 clear
    wr(3'd4, 8'h71); rd(3'd0, rd_val); chk("R4 clr 71", rd_val, 8'h8E);
    wr(3'd4, 8'h85); rd(3'd0, rd_val); chk("R4 clr 85", rd_val, 8'h0A);
    wr(3'd4, 8'hFF); rd(3'd0, rd_val); chk("R4 clr all", rd_val, 8'h00);

    // R2 each source pulse sets a sticky bit
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); src_req = 8'(1 << i);
      @(negedge clk); src_req = '0;
      repeat (2) @(posedge clk);
      rd(3'd0, rd_val); chk("R2 sticky source", rd_val, 8'(1 << i));
      wr(3'd4, 8'(1 << i));
    end

    // R5 source and clear on the same bit in the same cycle
    wr(3'd3, 8'h24);
    @(negedge clk);
    src_req = 8'h04; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h24;
    @(posedge clk); #1;
    src_req = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    rd(3'd0, rd_val); chk("R5 set beats clear", rd_val, 8'h04);
    wr(3'd4, 8'hFF);

    // R6 R7 sweep of all enable values
    for (int e = 0; e < 256; e++) begin
      m_ier = 8'(e);
      m_irr = 8'(e) ^ 8'(e * 37 + 11);
      wr(3'd4, 8'hFF);
      wr(3'd3, m_irr);
      wr(3'd1, m_ier);
      chk("R7 irq sweep", {7'b0, cpu_irq}, {7'b0, exp_irq()});
      rd(3'd2, rd_val); chk("R6 pending sweep", rd_val, m_irr & m_ier);
      rd(3'd1, rd_val); chk("R6 enable readback", rd_val, m_ier);
    end

    // R8 acknowledge drops irq while pending
    wr(3'd4, 8'hFF); wr(3'd3, 8'h10); wr(3'd1, 8'h10);
    m_irr = 8'h10; m_ier = 8'h10;
    chk("R7 irq on", {7'b0, cpu_irq}, 8'h01);
    @(negedge clk); cpu_ack = 1'b1;
    @(posedge clk); #1; cpu_ack = 1'b0;
    chk("R8 irq after ack", {7'b0, cpu_irq}, 8'h00);
    rd(3'd2, rd_val); chk("R8 still pending", rd_val, 8'h10);
    // R9 bit0=0 has no effect
    wr(3'd6, 8'hFE);
    chk("R9 write bit0 zero", {7'b0, cpu_irq}, 8'h00);
    wr(3'd6, 8'h01);
    chk("R9 allow restored", {7'b0, cpu_irq}, 8'h01);
    // R8 ack wins over simultaneous allow write
    @(negedge clk);
    cpu_ack = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h01;
    @(posedge clk); #1;
    cpu_ack = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    chk("R8 ack beats allow", {7'b0, cpu_irq}, 8'h00);
    wr(3'd6, 8'hFF);
    chk("R9 allow again", {7'b0, cpu_irq}, 8'h01);

    // R10 reserved reads and ignored strobes
    wr(3'd3, 8'hC3); m_irr = 8'hD3;
    for (int a = 3; a < 8; a++) begin
      rd(3'(a), rd_val); chk("R10 reserved read", rd_val, 8'h00);
    end
    rd(3'd0, rd_val); chk("R10 request read", rd_val, 8'hD3);
    // write without select ignored
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'hFF;
    @(posedge clk); #1; bus_wr = 1'b0; bus_wdata = '0;
    // read without select leaves rdata unchanged
    @(negedge clk); bus_rd = 1'b1; bus_addr = 3'd3;
    @(posedge clk); #1; bus_rd = 1'b0;
    chk("R10 rdata held", bus_rdata, 8'hD3);
    rd(3'd0, rd_val); chk("R10 unselected write ignored", rd_val, 8'hD3);
    repeat (3) @(posedge clk); #1;
    chk("R10 rdata stable idle", bus_rdata, 8'hD3);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 rdata after reset", bus_rdata, 8'h00);
    chk("R1 irq after reset", {7'b0, cpu_irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    rd(3'd0, rd_val); chk("R1 request cleared", rd_val, 8'h00);
    rd(3'd1, rd_val); chk("R1 enable cleared", rd_val, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule